// File: doc/BRIEF.md
# Pipeline Redirect and Precise Trap Controller

This block steers the fetch address of a six-stage in-order pipeline (stages IF, ID, RD, ALU, MEM, WB) whenever control flow leaves the sequential path. It owns the fetch PC register. In a cycle with no event, it advances that register by one instruction. Three kinds of event can redirect fetch:

- A taken branch resolved in ID. The target is formed by an adder local to the block from the ID-stage PC and a sign-extended offset.
- A trap. This is either a fault carried by the instruction now in MEM, or an asynchronous request taken at the MEM boundary.
- A return-from-interrupt instruction in MEM.

For every event the block drives one squash line per stage in the same cycle. The pipeline turns each squashed stage into a no-op at the next clock edge.

Traps are precise. The instruction in WB is older and always completes. The instruction in MEM and everything younger are squashed, so none of them changes architectural state. The MEM-stage PC is kept as the restart address, and the core's status word is saved alongside it. Fetch then moves to a single fixed handler vector, and the block enters privileged mode. Because every younger user instruction is already squashed, none of them can execute with privilege.

While privileged, further traps are masked. A return instruction in MEM restores the saved status through a one-cycle restore strobe, clears privileged mode, and resumes fetch at the saved PC. All pins are plain control or status signals, one value per cycle. There is no stream interface, so there is no back-pressure: the pipeline must act on the squash lines in the cycle they are driven.

Top module: `rdx_redirect_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `fetch_pc_o` equals RESET_PC, `priv_o` is 0, `squash_o` is 0 and `restore_o` is 0.
- R2: In a cycle with no event, `squash_o` is 0 and `fetch_pc_o` grows by STEP (default 4) at the next clock edge.
- R3: A taken branch (`id_br_taken` high) with no MEM-stage event drives `squash_o` = 6'b000001 in that cycle. Bit i of `squash_o` is stage i, with 0=IF, 1=ID, 2=RD, 3=ALU, 4=MEM, 5=WB. The next `fetch_pc_o` is `id_pc + id_off` modulo 2^PW, so negative offsets wrap.
- R4: In user mode, a valid MEM instruction with `mem_fault` high drives `squash_o` = 6'b011111 in that cycle. At the next edge, `fetch_pc_o` = VECTOR, `epc_o` = `mem_pc`, `estat_o` = `status_i` and `priv_o` = 1.
- R5: In user mode, `irq` is taken only together with a valid MEM instruction, with the same effects as R4. While `mem_valid` is low, `irq` has no effect.
- R6: While `priv_o` is 1, `irq` and `mem_fault` are ignored. There is no squash, fetch advances sequentially, and `epc_o` and `estat_o` keep their values.
- R7: In privileged mode, a valid MEM instruction with `mem_rfi` high drives `squash_o` = 6'b001111 and `restore_o` = 1 in that cycle, with `estat_o` giving the status to restore. At the next edge, `fetch_pc_o` = the saved `epc_o` and `priv_o` = 0.
- R8: A MEM-stage event (trap or return) in the same cycle as a taken branch wins. Squash and next PC follow the MEM event, not the branch.
- R9: `squash_o[5]` (WB) is never asserted. Squashed stages always form a contiguous run starting at IF.
- R10: In user mode, `mem_rfi` is ignored: no squash, no restore, fetch advances sequentially.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_br_taken | input | 1 | Branch in ID resolved taken |
| id_pc | input | PW | PC of the branch in ID |
| id_off | input | PW | Sign-extended branch offset |
| mem_valid | input | 1 | MEM stage holds a live instruction |
| mem_pc | input | PW | PC of the MEM-stage instruction |
| mem_fault | input | 1 | MEM-stage instruction carries a fault |
| mem_rfi | input | 1 | MEM-stage instruction is a return-from-interrupt |
| irq | input | 1 | Asynchronous interrupt request (level) |
| status_i | input | SW | Current status word of the core |
| fetch_pc_o | output | PW | Fetch PC register |
| squash_o | output | 6 | Per-stage squash, bit 0 = IF ... bit 5 = WB |
| priv_o | output | 1 | Privileged mode |
| epc_o | output | PW | Saved restart PC |
| estat_o | output | SW | Saved status word |
| restore_o | output | 1 | Strobe: load `estat_o` into the core status |

## Verification
A MEM-stage event and an ID-stage taken branch can occur in the same cycle. This is the collision the priority logic must settle. The bench holds a taken branch with a distinct target while raising `irq` with a valid MEM instruction in user mode. In a second case it raises `mem_rfi` in privileged mode alongside a branch. Each case is judged by the squash width in the cycle of the collision, and by whether the following fetch PC is the vector or the saved PC rather than the branch target.

// File: rtl/rdx_pkg.sv
package rdx_pkg;
  localparam int NSTG    = 6;
  localparam int STG_IF  = 0;
  localparam int STG_ID  = 1;
  localparam int STG_MEM = 4;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_BRANCH = 2'd1,
    EV_TRAP   = 2'd2,
    EV_RETURN = 2'd3
  } redir_e;
endpackage

// File: rtl/rdx_target_adder.sv
module rdx_target_adder #(
  parameter int PW = 32
) (
  input  logic [PW-1:0] base,
  input  logic [PW-1:0] off,
  output logic [PW-1:0] target
);
  // Dedicated decode-side adder: wraps modulo 2^PW.
  assign target = base + off;
endmodule

// File: rtl/rdx_arbiter.sv
module rdx_arbiter
  import rdx_pkg::*;
(
  input  logic            br_taken,
  input  logic            mem_valid,
  input  logic            mem_fault,
  input  logic            mem_rfi,
  input  logic            irq,
  input  logic            priv,
  output redir_e          ev,
  output logic [NSTG-1:0] squash
);
  localparam int KW = $clog2(NSTG);

  logic          trap_req, ret_req;
  logic          kill_en;
  logic [KW-1:0] kill_top;

  // Older events (MEM) beat younger ones (ID).
  assign trap_req = mem_valid && !priv && (mem_fault || irq);
  assign ret_req  = mem_valid && priv && mem_rfi;

  always_comb begin
    ev = EV_NONE;
    if (trap_req)      ev = EV_TRAP;
    else if (ret_req)  ev = EV_RETURN;
    else if (br_taken) ev = EV_BRANCH;
  end

  // Highest stage index to kill; everything from IF up to it is squashed.
  always_comb begin
    kill_en  = 1'b1;
    kill_top = KW'(STG_IF);
    unique case (ev)
      EV_TRAP:   kill_top = KW'(STG_MEM);
      EV_RETURN: kill_top = KW'(STG_MEM - 1);
      EV_BRANCH: kill_top = KW'(STG_ID - 1);
      default:   kill_en  = 1'b0;
    endcase
  end

  for (genvar s = 0; s < NSTG; s++) begin : g_sq
    assign squash[s] = kill_en && (KW'(s) <= kill_top);
  end
endmodule

// File: rtl/rdx_state.sv
module rdx_state
  import rdx_pkg::*;
#(
  parameter int          PW       = 32,
  parameter int          SW       = 8,
  parameter logic [PW-1:0] RESET_PC = '0,
  parameter logic [PW-1:0] VECTOR   = '0,
  parameter int          STEP     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  redir_e        ev,
  input  logic [PW-1:0] br_target,
  input  logic [PW-1:0] mem_pc,
  input  logic [SW-1:0] status_i,
  output logic [PW-1:0] fetch_pc,
  output logic [PW-1:0] epc,
  output logic [SW-1:0] estat,
  output logic          priv
);
  logic [PW-1:0] pc_nxt;

  always_comb begin
    unique case (ev)
      EV_TRAP:   pc_nxt = VECTOR;
      EV_RETURN: pc_nxt = epc;
      EV_BRANCH: pc_nxt = br_target;
      default:   pc_nxt = fetch_pc + PW'(STEP);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_pc <= RESET_PC;
      epc      <= '0;
      estat    <= '0;
      priv     <= 1'b0;
    end else begin
      fetch_pc <= pc_nxt;
      if (ev == EV_TRAP) begin
        epc   <= mem_pc;
        estat <= status_i;
        priv  <= 1'b1;
      end else if (ev == EV_RETURN) begin
        priv  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rdx_redirect_ctrl.sv
module rdx_redirect_ctrl
  import rdx_pkg::*;
#(
  parameter int            PW       = 32,
  parameter int            SW       = 8,
  parameter logic [PW-1:0] RESET_PC = 32'h0000_1000,
  parameter logic [PW-1:0] VECTOR   = 32'h0000_0080,
  parameter int            STEP     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          id_br_taken,
  input  logic [PW-1:0] id_pc,
  input  logic [PW-1:0] id_off,
  input  logic          mem_valid,
  input  logic [PW-1:0] mem_pc,
  input  logic          mem_fault,
  input  logic          mem_rfi,
  input  logic          irq,
  input  logic [SW-1:0] status_i,
  output logic [PW-1:0] fetch_pc_o,
  output logic [5:0]    squash_o,
  output logic          priv_o,
  output logic [PW-1:0] epc_o,
  output logic [SW-1:0] estat_o,
  output logic          restore_o
);
  redir_e        ev;
  logic [PW-1:0] br_target;

  rdx_target_adder #(.PW(PW)) u_add (
    .base   (id_pc),
    .off    (id_off),
    .target (br_target)
  );

  rdx_arbiter u_arb (
    .br_taken  (id_br_taken),
    .mem_valid (mem_valid),
    .mem_fault (mem_fault),
    .mem_rfi   (mem_rfi),
    .irq       (irq),
    .priv      (priv_o),
    .ev        (ev),
    .squash    (squash_o)
  );

  rdx_state #(
    .PW(PW), .SW(SW), .RESET_PC(RESET_PC), .VECTOR(VECTOR), .STEP(STEP)
  ) u_st (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev),
    .br_target (br_target),
    .mem_pc    (mem_pc),
    .status_i  (status_i),
    .fetch_pc  (fetch_pc_o),
    .epc       (epc_o),
    .estat     (estat_o),
    .priv      (priv_o)
  );

  assign restore_o = (ev == EV_RETURN);
endmodule

// File: rtl/rdx_redirect_ctrl_chk.sv
module rdx_redirect_ctrl_chk
  import rdx_pkg::*;
#(
  parameter int            PW     = 32,
  parameter logic [PW-1:0] VECTOR = '0,
  parameter int            STEP   = 4
) (
  input logic          clk,
  input logic          rst_n,
  input redir_e        ev,
  input logic [PW-1:0] id_pc,
  input logic [PW-1:0] id_off,
  input logic [PW-1:0] mem_pc,
  input logic [PW-1:0] fetch_pc_o,
  input logic [5:0]    squash_o,
  input logic          priv_o,
  input logic [PW-1:0] epc_o,
  input logic          restore_o
);
  // R2
  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_NONE |=> fetch_pc_o == $past(fetch_pc_o) + PW'(STEP));
  // R3
  a_r3_branch_target: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_BRANCH |=> fetch_pc_o == $past(id_pc) + $past(id_off));
  // R4, R5
  a_r4_trap_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_TRAP |=> fetch_pc_o == VECTOR && priv_o && epc_o == $past(mem_pc));
  // R6
  a_r6_masked: assert property (@(posedge clk) disable iff (!rst_n)
    priv_o |-> ev != EV_TRAP);
  // R7
  a_r7_return: assert property (@(posedge clk) disable iff (!rst_n)
    restore_o |=> fetch_pc_o == $past(epc_o) && !priv_o);
  a_r7_restore_priv: assert property (@(posedge clk) disable iff (!rst_n)
    restore_o |-> priv_o);
  // R9
  a_r9_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(squash_o + 6'd1) <= 1 && !squash_o[5]);
endmodule

bind rdx_redirect_ctrl rdx_redirect_ctrl_chk #(
  .PW(PW), .VECTOR(VECTOR), .STEP(STEP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev         (ev),
  .id_pc      (id_pc),
  .id_off     (id_off),
  .mem_pc     (mem_pc),
  .fetch_pc_o (fetch_pc_o),
  .squash_o   (squash_o),
  .priv_o     (priv_o),
  .epc_o      (epc_o),
  .restore_o  (restore_o)
);

// File: tb/rdx_redirect_ctrl_test.sv
module rdx_redirect_ctrl_test;
  localparam logic [31:0] RST_PC = 32'h0000_1000;
  localparam logic [31:0] VEC    = 32'h0000_0080;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        id_br_taken = 1'b0;
  logic [31:0] id_pc = '0, id_off = '0, mem_pc = '0;
  logic        mem_valid = 1'b0, mem_fault = 1'b0, mem_rfi = 1'b0, irq = 1'b0;
  logic [7:0]  status_i = '0;
  logic [31:0] fetch_pc_o, epc_o;
  logic [5:0]  squash_o;
  logic        priv_o, restore_o;
  logic [7:0]  estat_o;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  rdx_redirect_ctrl uut (
    .clk(clk), .rst_n(rst_n), .id_br_taken(id_br_taken), .id_pc(id_pc),
    .id_off(id_off), .mem_valid(mem_valid), .mem_pc(mem_pc),
    .mem_fault(mem_fault), .mem_rfi(mem_rfi), .irq(irq), .status_i(status_i),
    .fetch_pc_o(fetch_pc_o), .squash_o(squash_o), .priv_o(priv_o),
    .epc_o(epc_o), .estat_o(estat_o), .restore_o(restore_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    id_br_taken = 0; mem_valid = 0; mem_fault = 0; mem_rfi = 0; irq = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 pc in reset", fetch_pc_o, RST_PC);
    rst_n = 1'b1;
    #1;
    chk("R1 pc after release", fetch_pc_o, RST_PC);
    chk("R1 priv", 32'(priv_o), 0);
    chk("R1 squash", 32'(squash_o), 0);
    chk("R1 restore", 32'(restore_o), 0);
  endtask

  task automatic t_seq();
    logic [31:0] p;
    @(negedge clk); p = fetch_pc_o;
    chk("R2 squash idle", 32'(squash_o), 0);
    @(negedge clk);
    chk("R2 pc step", fetch_pc_o, p + 4);
  endtask

  task automatic t_branch(logic [31:0] pc, logic [31:0] off);
    @(negedge clk);
    id_br_taken = 1; id_pc = pc; id_off = off;
    #1 chk("R3 branch squash", 32'(squash_o), 32'h01);
    @(negedge clk); idle();
    chk("R3 branch target", fetch_pc_o, pc + off);
  endtask

  task automatic t_fault(logic [31:0] pc, logic [7:0] st);
    @(negedge clk);
    mem_valid = 1; mem_fault = 1; mem_pc = pc; status_i = st;
    #1 chk("R4 fault squash", 32'(squash_o), 32'h1F);
    @(negedge clk); idle();
    chk("R4 vector", fetch_pc_o, VEC);
    chk("R4 epc", epc_o, pc);
    chk("R4 estat", 32'(estat_o), 32'(st));
    chk("R4 priv", 32'(priv_o), 1);
  endtask

  task automatic t_masked(logic [31:0] old_epc);
    logic [31:0] p;
    @(negedge clk);
    p = fetch_pc_o;
    mem_valid = 1; irq = 1; mem_fault = 1; mem_pc = 32'hDEAD_0000; status_i = 8'hFF;
    #1 chk("R6 masked squash", 32'(squash_o), 0);
    @(negedge clk); idle();
    chk("R6 masked pc", fetch_pc_o, p + 4);
    chk("R6 epc kept", epc_o, old_epc);
    chk("R6 priv kept", 32'(priv_o), 1);
  endtask

  task automatic t_return(logic [31:0] saved, logic [7:0] st);
    @(negedge clk);
    mem_valid = 1; mem_rfi = 1; mem_pc = 32'h0000_0090;
    #1;
    chk("R7 return squash", 32'(squash_o), 32'h0F);
    chk("R7 restore strobe", 32'(restore_o), 1);
    chk("R7 restore status", 32'(estat_o), 32'(st));
    @(negedge clk); idle();
    chk("R7 resume pc", fetch_pc_o, saved);
    chk("R7 priv cleared", 32'(priv_o), 0);
  endtask

  task automatic t_irq();
    logic [31:0] p;
    @(negedge clk);
    p = fetch_pc_o; irq = 1; mem_valid = 0;
    #1 chk("R5 irq no slot squash", 32'(squash_o), 0);
    @(negedge clk);
    chk("R5 irq waits pc", fetch_pc_o, p + 4);
    chk("R5 irq waits priv", 32'(priv_o), 0);
    mem_valid = 1; mem_pc = 32'h0000_3000; status_i = 8'h11;
    #1 chk("R5 irq squash", 32'(squash_o), 32'h1F);
    @(negedge clk); idle();
    chk("R5 irq vector", fetch_pc_o, VEC);
    chk("R5 irq epc", epc_o, 32'h0000_3000);
  endtask

  task automatic t_prio_trap();
    @(negedge clk);
    id_br_taken = 1; id_pc = 32'h500; id_off = 32'h100;
    mem_valid = 1; irq = 1; mem_pc = 32'h0000_4000; status_i = 8'h22;
    #1 chk("R8 trap over branch squash", 32'(squash_o), 32'h1F);
    @(negedge clk); idle();
    chk("R8 trap over branch pc", fetch_pc_o, VEC);
    chk("R8 trap epc", epc_o, 32'h0000_4000);
  endtask

  task automatic t_prio_ret();
    @(negedge clk);
    id_br_taken = 1; id_pc = 32'h500; id_off = 32'h100;
    mem_valid = 1; mem_rfi = 1;
    #1 chk("R8 return over branch squash", 32'(squash_o), 32'h0F);
    @(negedge clk); idle();
    chk("R8 return over branch pc", fetch_pc_o, 32'h0000_4000);
  endtask

  task automatic t_user_rfi();
    logic [31:0] p;
    @(negedge clk);
    p = fetch_pc_o; mem_valid = 1; mem_rfi = 1;
    #1;
    chk("R10 user rfi squash", 32'(squash_o), 0);
    chk("R10 user rfi restore", 32'(restore_o), 0);
    chk("R9 wb never squashed", 32'(squash_o[5]), 0);
    @(negedge clk); idle();
    chk("R10 user rfi pc", fetch_pc_o, p + 4);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_seq();
    t_branch(32'h0000_0100, 32'h0000_0040);
    t_branch(32'h0000_0004, 32'hFFFF_FFF0);
    t_fault(32'h0000_2000, 8'h5A);
    t_masked(32'h0000_2000);
    t_return(32'h0000_2000, 8'h5A);
    t_irq();
    t_return(32'h0000_3000, 8'h11);
    t_prio_trap();
    t_prio_ret();
    t_user_rfi();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule